// File: doc/BRIEF.md
# I2C Start/Stop Hold-Time Qualifier

This block watches the clock and data lines of an I2C bus for a slave-side controller and decides when a START or a STOP condition has really occurred. Both lines are first brought into the system clock domain. The synchronized lines are then sampled on a tick that runs at half the system clock rate. A START candidate is a falling data edge while the clock line is high. A STOP candidate is a rising data edge while the clock line is high. A candidate is confirmed only after the data level has stayed put, with the clock line still high, for a programmable number of sample ticks. Each confirmed condition produces a one-cycle pulse, and a bus-busy flag follows them.

An 8-bit setup register selects the hold length. Bit 7 enables the programmable count, and bits 6..0 hold the count minus one. A second 8-bit register stores the controller's own 7-bit slave address and shows it on an output. The condition detector is a three-state machine:
- `HQ_IDLE` waits for an edge on the data line.
- `HQ_START_CAND` counts a low data level.
- `HQ_STOP_CAND` counts a high data level.

Transitions of the state machine:
- *open-start* (IDLE→START_CAND on a falling edge) and *open-stop* (IDLE→STOP_CAND on a rising edge). When the length is one sample, either of these qualifies at once and the machine stays in IDLE.
- *confirm* (a candidate state reaches its length and returns to IDLE with a pulse).
- *abort* (a candidate state sees the clock line low and returns to IDLE).
- *flip* (a candidate state sees the opposite data edge with the clock line high and opens the other candidate with a fresh count).

Top module: `i2c_hold_qual`

## Requirements
- R1: After reset the start, stop and busy outputs are 0, the own-address output is 0, and the setup register is 0x00, so conditions qualify after one sample.
- R2: While setup bit 7 is 0, bits 6..0 have no effect and the required length is one sample.
- R3: While setup bit 7 is 1, the required length is (bits 6..0) + 1 samples, from 1 to 128. Samples are taken on every second system clock, so a data level held 2·N+2 clocks qualifies and one held 2·N−3 clocks does not.
- R4: A falling data edge with the clock line high, held for the required length, produces a START pulse.
- R5: A rising data edge with the clock line high, held for the required length, produces a STOP pulse.
- R6: If the clock line goes low before the count completes, the candidate is dropped and no pulse is produced.
- R7: START and STOP pulses last exactly one system clock and never occur together.
- R8: Busy is set in the cycle after a START pulse and cleared in the cycle after a STOP pulse.
- R9: A setup write during a count does not change that count's length. The new value applies from the next candidate onward.
- R10: A write to the address register stores data bits 7..1 as the 7-bit own address. Bit 0 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| setup_we_i | input | 1 | Write strobe for the setup register |
| setup_wdata_i | input | 8 | Setup value: bit 7 enable, bits 6..0 length minus one |
| addr_we_i | input | 1 | Write strobe for the own-address register |
| addr_wdata_i | input | 8 | Address value: bits 7..1 address, bit 0 ignored |
| own_addr_o | output | 7 | Stored own slave address |
| start_o | output | 1 | One-cycle pulse on a qualified START |
| stop_o | output | 1 | One-cycle pulse on a qualified STOP |
| busy_o | output | 1 | High between a qualified START and a qualified STOP |

## Verification
The assertions assume the raw lines change at most once every few system clocks and that the data line and the clock line never switch in the same cycle. Edge ordering on the bus is therefore well defined after synchronization. The stimulus always moves one line at a time and waits several clocks between changes. It only moves the data line while the clock line is low, except when it deliberately forms a START or STOP candidate. Hold windows are chosen 2·N+2 or 2·N−3 clocks long, so that the outcome does not depend on the phase of the sample tick.

// File: rtl/i2c_hold_qual_pkg.sv
package i2c_hold_qual_pkg;
    localparam int HQ_LEN_W  = 7;
    localparam int HQ_CNT_W  = HQ_LEN_W + 1;
    localparam int HQ_EN_BIT = 7;

    typedef enum logic [1:0] {
        HQ_IDLE       = 2'd0,
        HQ_START_CAND = 2'd1,
        HQ_STOP_CAND  = 2'd2
    } hq_state_e;
endpackage

// File: rtl/hq_line_sync.sv
module hq_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q <= '1;
            else         chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        end
        assign sync_o[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/hq_tick_gen.sv
module hq_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + CW'(1);
    end

    assign tick_o = (div_q == LAST);

    // Ticks are isolated: sampling runs at a fraction of the system clock (R3)
    p_tick_isolated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
endmodule

// File: rtl/hq_cond_fsm.sv
module hq_cond_fsm
    import i2c_hold_qual_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                tick_i,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                cfg_en_i,
    input  logic [HQ_LEN_W-1:0] cfg_len_i,
    output logic                start_o,
    output logic                stop_o
);
    hq_state_e           st_q, st_n;
    logic [HQ_CNT_W-1:0] cnt_q, cnt_n;
    logic [HQ_CNT_W-1:0] need_q, need_n;
    logic                sda_prev_q;
    logic                start_f, stop_f;

    logic [HQ_CNT_W-1:0] need_now;
    logic                fall_hit, rise_hit, one_shot;
    logic [HQ_CNT_W-1:0] cnt_inc;

    // Length picked up when a candidate opens
    assign need_now = cfg_en_i ? ({1'b0, cfg_len_i} + HQ_CNT_W'(1)) : HQ_CNT_W'(1);
    assign fall_hit = tick_i && scl_i && sda_prev_q && !sda_i;
    assign rise_hit = tick_i && scl_i && !sda_prev_q && sda_i;
    assign one_shot = (need_now == HQ_CNT_W'(1));
    assign cnt_inc  = cnt_q + HQ_CNT_W'(1);

    // State register process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= HQ_IDLE;
            cnt_q      <= '0;
            need_q     <= HQ_CNT_W'(1);
            sda_prev_q <= 1'b1;
        end else begin
            st_q   <= st_n;
            cnt_q  <= cnt_n;
            need_q <= need_n;
            if (tick_i) sda_prev_q <= sda_i;
        end
    end

    // Next-state logic
    always_comb begin
        st_n    = st_q;
        cnt_n   = cnt_q;
        need_n  = need_q;
        start_f = 1'b0;
        stop_f  = 1'b0;
        unique case (st_q)
            HQ_IDLE: begin
                if (fall_hit) begin
                    if (one_shot) start_f = 1'b1;
                    else begin
                        st_n   = HQ_START_CAND;
                        cnt_n  = HQ_CNT_W'(1);
                        need_n = need_now;
                    end
                end else if (rise_hit) begin
                    if (one_shot) stop_f = 1'b1;
                    else begin
                        st_n   = HQ_STOP_CAND;
                        cnt_n  = HQ_CNT_W'(1);
                        need_n = need_now;
                    end
                end
            end
            HQ_START_CAND: begin
                if (tick_i) begin
                    if (rise_hit) begin
                        // flip: the opposite edge opens a STOP candidate
                        if (one_shot) begin
                            stop_f = 1'b1;
                            st_n   = HQ_IDLE;
                        end else begin
                            st_n   = HQ_STOP_CAND;
                            cnt_n  = HQ_CNT_W'(1);
                            need_n = need_now;
                        end
                    end else if (!scl_i) begin
                        st_n = HQ_IDLE;
                    end else if (cnt_inc == need_q) begin
                        start_f = 1'b1;
                        st_n    = HQ_IDLE;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
            end
            HQ_STOP_CAND: begin
                if (tick_i) begin
                    if (fall_hit) begin
                        if (one_shot) begin
                            start_f = 1'b1;
                            st_n    = HQ_IDLE;
                        end else begin
                            st_n   = HQ_START_CAND;
                            cnt_n  = HQ_CNT_W'(1);
                            need_n = need_now;
                        end
                    end else if (!scl_i) begin
                        st_n = HQ_IDLE;
                    end else if (cnt_inc == need_q) begin
                        stop_f = 1'b1;
                        st_n   = HQ_IDLE;
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
            end
            default: st_n = HQ_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            start_o <= 1'b0;
            stop_o  <= 1'b0;
        end else begin
            start_o <= start_f;
            stop_o  <= stop_f;
        end
    end

    p_cnt_below_need_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q != HQ_IDLE) |-> (cnt_q < need_q));

    p_need_frozen_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == HQ_START_CAND) && ($past(st_q) == HQ_START_CAND)) |-> $stable(need_q));

    p_need_frozen_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q == HQ_STOP_CAND) && ($past(st_q) == HQ_STOP_CAND)) |-> $stable(need_q));

    p_abort_on_scl_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q != HQ_IDLE) && tick_i && !scl_i) |=> (st_q == HQ_IDLE) && !start_o && !stop_o);

    p_start_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);

    p_stop_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_o |=> !stop_o);
endmodule

// File: rtl/i2c_hold_qual.sv
module i2c_hold_qual
    import i2c_hold_qual_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TICK_DIV    = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       setup_we_i,
    input  logic [7:0] setup_wdata_i,
    input  logic       addr_we_i,
    input  logic [7:0] addr_wdata_i,
    output logic [6:0] own_addr_o,
    output logic       start_o,
    output logic       stop_o,
    output logic       busy_o
);
    logic [7:0] setup_q;
    logic [6:0] addr_q;
    logic       busy_q;
    logic [1:0] lines_s;
    logic       tick;
    logic       unused_addr_lsb;

    assign unused_addr_lsb = addr_wdata_i[0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            setup_q <= 8'h00;
            addr_q  <= '0;
        end else begin
            if (setup_we_i) setup_q <= setup_wdata_i;
            if (addr_we_i)  addr_q  <= addr_wdata_i[7:1];
        end
    end
    assign own_addr_o = addr_q;

    hq_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  ({scl_i, sda_i}),
        .sync_o (lines_s)
    );

    hq_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    hq_cond_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .scl_i     (lines_s[1]),
        .sda_i     (lines_s[0]),
        .cfg_en_i  (setup_q[HQ_EN_BIT]),
        .cfg_len_i (setup_q[HQ_LEN_W-1:0]),
        .start_o   (start_o),
        .stop_o    (stop_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      busy_q <= 1'b0;
        else if (start_o) busy_q <= 1'b1;
        else if (stop_o)  busy_q <= 1'b0;
    end
    assign busy_o = busy_q;

    p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(start_o && stop_o));

    p_busy_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> busy_o);

    p_busy_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_o |=> !busy_o);

    p_addr_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_we_i |=> (own_addr_o == $past(addr_wdata_i[7:1])));
endmodule

// File: tb/i2c_hold_qual_tb_top.sv
module i2c_hold_qual_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       setup_we = 1'b0, addr_we = 1'b0;
    logic [7:0] setup_wd = 8'h00, addr_wd = 8'h00;
    logic [6:0] own_addr;
    logic       start_p, stop_p, busy;

    int vecs = 0, errs = 0;
    int starts = 0, stops = 0;
    int run_s = 0, run_p = 0, max_s = 0, max_p = 0;
    bit overlap = 1'b0;

    always #4 clk = ~clk;

    i2c_hold_qual dut_i (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
        .setup_we_i(setup_we), .setup_wdata_i(setup_wd),
        .addr_we_i(addr_we), .addr_wdata_i(addr_wd),
        .own_addr_o(own_addr), .start_o(start_p), .stop_o(stop_p), .busy_o(busy)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (start_p) begin starts++; run_s++; if (run_s > max_s) max_s = run_s; end
            else run_s = 0;
            if (stop_p) begin stops++; run_p++; if (run_p > max_p) max_p = run_p; end
            else run_p = 0;
            if (start_p && stop_p) overlap = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_setup(input logic [7:0] v);
        setup_we = 1'b1; setup_wd = v; w(1); setup_we = 1'b0;
    endtask

    // Put the bus back into idle (clock high, data high) without a condition
    task automatic go_idle_low_then_high();
        scl = 1'b0; w(4); sda = 1'b1; w(4); scl = 1'b1; w(6);
    endtask

    task automatic sweep_cfg(input logic [7:0] v);
        int n, s0, p0;
        string tg;
        n  = v[7] ? int'(v[6:0]) + 1 : 1;
        tg = v[7] ? "R3" : "R2";
        wr_setup(v);
        if (n >= 2) begin
            // R6 short START glitch cut by clock low
            s0 = starts; sda = 1'b0; w(2*n - 3); scl = 1'b0; w(6);
            chk(starts == s0, {tg, "/R6 short start"}, starts - s0, 0);
            chk(busy == 1'b0, "R8 busy stays low", busy, 0);
            go_idle_low_then_high();
        end
        // R4 long START
        s0 = starts; sda = 1'b0; w(2*n + 2); w(6);
        chk(starts == s0 + 1, {tg, "/R4 long start"}, starts - s0, 1);
        chk(busy == 1'b1, "R8 busy set", busy, 1);
        if (n >= 2) begin
            // R6 short STOP glitch cut by clock low
            p0 = stops; sda = 1'b1; w(2*n - 3); scl = 1'b0; w(6);
            chk(stops == p0, {tg, "/R6 short stop"}, stops - p0, 0);
            chk(busy == 1'b1, "R8 busy kept", busy, 1);
            w(2); sda = 1'b0; w(4); scl = 1'b1; w(6);
        end
        // R5 long STOP
        p0 = stops; sda = 1'b1; w(2*n + 2); w(6);
        chk(stops == p0 + 1, {tg, "/R5 long stop"}, stops - p0, 1);
        chk(busy == 1'b0, "R8 busy cleared", busy, 0);
    endtask

    initial begin
        int s0, p0;
        w(3); rst_n = 1'b1; w(4);
        // R1 reset state
        chk(start_p == 1'b0 && stop_p == 1'b0, "R1 pulses low", start_p + stop_p, 0);
        chk(busy == 1'b0, "R1 busy low", busy, 0);
        chk(own_addr == 7'h00, "R1 own address", own_addr, 0);
        // R1 default one-sample: 3-clock hold qualifies
        s0 = starts; sda = 1'b0; w(3); scl = 1'b0; w(6);
        chk(starts == s0 + 1, "R1 default one sample", starts - s0, 1);
        w(2); scl = 1'b1; w(6);
        p0 = stops; sda = 1'b1; w(10);
        chk(stops == p0 + 1, "R1 stop", stops - p0, 1);

        // R2 bits 6..0 ignored when bit 7 is clear
        wr_setup(8'h7F);
        s0 = starts; sda = 1'b0; w(3); scl = 1'b0; w(6);
        chk(starts == s0 + 1, "R2 0x7F acts as one sample", starts - s0, 1);
        w(2); scl = 1'b1; w(6); sda = 1'b1; w(10);

        sweep_cfg(8'h00);
        sweep_cfg(8'h7F);
        for (int k = 8'h80; k <= 8'h88; k++) sweep_cfg(8'(k));
        sweep_cfg(8'h8B);
        sweep_cfg(8'hFF);

        // R9 write during a count keeps the old length (8)
        wr_setup(8'h87);
        s0 = starts; sda = 1'b0; w(3); wr_setup(8'h80); w(9); scl = 1'b0; w(6);
        chk(starts == s0, "R9 in-flight count unchanged", starts - s0, 0);
        go_idle_low_then_high();
        s0 = starts; sda = 1'b0; w(3); scl = 1'b0; w(6);
        chk(starts == s0 + 1, "R9 new length on next candidate", starts - s0, 1);
        w(2); scl = 1'b1; w(6); sda = 1'b1; w(10);
        chk(busy == 1'b0, "R8 busy after R9 stop", busy, 0);

        // R10 own address
        addr_we = 1'b1; addr_wd = 8'hA5; w(1); addr_we = 1'b0; w(1);
        chk(own_addr == 7'h52, "R10 address 0xA5", own_addr, 'h52);
        addr_we = 1'b1; addr_wd = 8'h01; w(1); addr_we = 1'b0; w(1);
        chk(own_addr == 7'h00, "R10 bit 0 dropped", own_addr, 0);

        // R7 pulse shape over the whole run
        chk(max_s == 1, "R7 start width", max_s, 1);
        chk(max_p == 1, "R7 stop width", max_p, 1);
        chk(overlap == 1'b0, "R7 no overlap", overlap, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule